// File: doc/BRIEF.md
# I2C Status and Power-Enable Register Target

This block is an I2C target that sits on a board-management I2C bus and exposes a small register map, indexed by a byte. Software reads through it the firmware and board revision codes, the enable state of the power groups, sixteen debounced power-good bits and the power sequencer's active-low fault flag. One register can also be written, and its lowest bit drives an enable line for a USB supply.

A transaction with the write direction carries the register index in its first data byte, and any further bytes are written starting at that index. A transaction with the read direction returns bytes starting at the current index. The index steps by one after every data byte in either direction, so burst access and the usual combined format (index write, repeated START, read) both work. Both bus lines pass through a synchronizer and a glitch filter before any START, STOP or bit is decoded. The block drives SDA through a single pull-down enable and never drives SCL.

Top module: `i2cStatusTarget`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x55 (SDA pulled low in the ninth clock of the address byte). For any other address it acknowledges nothing and leaves SDA released until the next START or STOP.
- R2: The first data byte of a write transaction loads the register index. The index then rises by one after each further data byte written and after each byte read, and wraps from 0xFF to 0x00.
- R3: A read returns the byte at the current index. Index 0x00 returns the firmware-revision input and index 0x01 returns the board-revision input.
- R4: Index 0x06 returns the power-group enable byte. Index 0x08 returns power-good bits 7:0 and index 0x09 returns power-good bits 15:8.
- R5: Index 0x0A returns the active-low sequencer fault input in bit 0, with bits 7:1 reading zero.
- R6: Writing index 0x0E sets `usbPowerEn` to bit 0 of the written byte. A read of index 0x0E returns {7'b0, usbPowerEn}. `usbPowerEn` is 0 after reset.
- R7: Data bytes written to any index other than 0x0E are acknowledged and change nothing. Reads from indices that hold no register return 0x00.
- R8: A START arriving in the middle of a byte discards the partial byte, leaves the index and the registers unchanged, and begins a new address phase.
- R9: SCL and SDA each pass through a two-flop synchronizer and a filter. A pulse shorter than FILT_LEN clock cycles produces no bit, no START and no STOP.
- R10: The target changes its SDA drive only while the filtered SCL is low. Read data goes out most significant bit first. A NACK from the controller ends the read with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sdaDriveLow | output | 1 | When 1, the open-drain SDA driver pulls the line low |
| fwRevision | input | 8 | Firmware revision code, read at index 0x00 |
| boardRevision | input | 8 | Board revision code, read at index 0x01 |
| groupEnable | input | 8 | Power-group enable status, read at index 0x06 |
| powerGood | input | 16 | Debounced power-good bits, read at 0x08 and 0x09 |
| seqFaultN | input | 1 | Sequencer fault flag, active low, read at index 0x0A |
| usbPowerEn | output | 1 | USB supply enable, bit 0 of index 0x0E |

## Verification
A bus-functional controller on an open-drain model of SDA runs several kinds of traffic:
- **Sixteen-byte burst reads from index 0.** These separate each mapped index from its neighbours and from the zero returned for unmapped indices.
- **Reads after the status inputs change to asymmetric values.** These show that each byte comes from the right input and the right half of the power-good vector.
- **Burst writes across the read-only indices.** These show that auto-increment reaches 0x0E while nothing else moves.
- **Index-only writes followed by plain reads, and reads that run across 0xFF.** These tell the stored index apart from an index reset, and check the wrap.
- **A wrong address, an index write cut short by a repeated START, and one-cycle glitches on SCL and on SDA.** Each of these must leave the enable output exactly where a behavioural model of the register expects it, compared on every clock.

// File: rtl/i2cStatusPkg.sv
package i2cStatusPkg;

  localparam int BYTE_W = 8;
  localparam int PG_BITS = 16;

  // Register indices; software depends on these positions.
  localparam logic [BYTE_W-1:0] IDX_FW    = 8'h00;
  localparam logic [BYTE_W-1:0] IDX_BOARD = 8'h01;
  localparam logic [BYTE_W-1:0] IDX_GROUP = 8'h06;
  localparam logic [BYTE_W-1:0] IDX_PG_LO = 8'h08;
  localparam logic [BYTE_W-1:0] IDX_PG_HI = 8'h09;
  localparam logic [BYTE_W-1:0] IDX_FAULT = 8'h0A;
  localparam logic [BYTE_W-1:0] IDX_USB   = 8'h0E;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } busState_e;

  // Strobes from the bus control to the byte datapath.
  typedef struct packed {
    logic shiftIn;
    logic shiftBit;
    logic loadRead;
    logic shiftOut;
    logic setIndex;
    logic writeReg;
    logic incIndex;
  } dpStrobe_t;

endpackage

// File: rtl/i2cLineFilter.sv
module i2cLineFilter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0] diffCnt;
  logic syncOut;

  assign syncOut = syncQ[SYNC_STAGES-1];

  // Idle bus level is high, so everything resets to 1.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '1;
      diffCnt <= '0;
      lineOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      if (syncOut == lineOut) begin
        diffCnt <= '0;
      end else if (diffCnt == CNT_W'(FILT_LEN - 1)) begin
        lineOut <= syncOut;
        diffCnt <= '0;
      end else begin
        diffCnt <= diffCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cBusControl.sv
module i2cBusControl
  import i2cStatusPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      txMsb,
  output dpStrobe_t strb,
  output logic      sdaDriveLow
);
  busState_e state;
  logic [3:0] bitCnt;
  logic firstByte, rdNack, sclPrev, sdaPrev;
  logic startDet, stopDet, sclRise, sclFall;

  assign startDet = sclF && sclPrev && sdaPrev && !sdaF;
  assign stopDet  = sclF && sclPrev && !sdaPrev && sdaF;
  assign sclRise  = sclF && !sclPrev;
  assign sclFall  = !sclF && sclPrev;

  always_comb begin
    strb = '0;
    strb.shiftBit = sdaF;
    if (!startDet && !stopDet) begin
      case (state)
        ST_ADDR: strb.shiftIn = sclRise && (bitCnt != 4'd8);
        ST_WR: begin
          strb.shiftIn = sclRise && (bitCnt != 4'd8);
          if (sclFall && bitCnt == 4'd8) begin
            strb.setIndex = firstByte;
            strb.writeReg = !firstByte;
            strb.incIndex = !firstByte;
          end
        end
        ST_ADDR_ACK: strb.loadRead = sclFall && rwBit;
        ST_RD: begin
          strb.incIndex = sclFall && (bitCnt == 4'd7);
          strb.shiftOut = sclFall && (bitCnt != 4'd7);
        end
        ST_RD_ACK: strb.loadRead = sclFall && !rdNack;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      firstByte <= 1'b0;
      rdNack    <= 1'b0;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
      end else if (stopDet) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ADDR: begin
            if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 1'b1;
            if (sclFall && bitCnt == 4'd8) state <= addrMatch ? ST_ADDR_ACK : ST_SKIP;
          end
          ST_ADDR_ACK: if (sclFall) begin
            bitCnt    <= '0;
            firstByte <= 1'b1;
            state     <= rwBit ? ST_RD : ST_WR;
          end
          ST_WR: begin
            if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 1'b1;
            if (sclFall && bitCnt == 4'd8) begin
              state     <= ST_WR_ACK;
              firstByte <= 1'b0;
            end
          end
          ST_WR_ACK: if (sclFall) begin
            state  <= ST_WR;
            bitCnt <= '0;
          end
          ST_RD: if (sclFall) begin
            if (bitCnt == 4'd7) state <= ST_RD_ACK;
            else bitCnt <= bitCnt + 1'b1;
          end
          ST_RD_ACK: begin
            if (sclRise) rdNack <= sdaF;
            if (sclFall) begin
              state  <= rdNack ? ST_SKIP : ST_RD;
              bitCnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                       ((state == ST_RD) && !txMsb);
endmodule

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cStatusPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h55
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [BYTE_W-1:0]  fwRevision,
  input  logic [BYTE_W-1:0]  boardRevision,
  input  logic [BYTE_W-1:0]  groupEnable,
  input  logic [PG_BITS-1:0] powerGood,
  input  logic               seqFaultN,
  output logic               addrMatch,
  output logic               rwBit,
  output logic               txMsb,
  output logic [BYTE_W-1:0]  curIndex,
  output logic               usbPowerEn
);
  logic [BYTE_W-1:0] shiftQ;
  logic [BYTE_W-1:0] readByte;

  always_comb begin
    case (curIndex)
      IDX_FW:    readByte = fwRevision;
      IDX_BOARD: readByte = boardRevision;
      IDX_GROUP: readByte = groupEnable;
      IDX_PG_LO: readByte = powerGood[BYTE_W-1:0];
      IDX_PG_HI: readByte = powerGood[PG_BITS-1:BYTE_W];
      IDX_FAULT: readByte = {{(BYTE_W-1){1'b0}}, seqFaultN};
      IDX_USB:   readByte = {{(BYTE_W-1){1'b0}}, usbPowerEn};
      default:   readByte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ     <= '0;
      curIndex   <= '0;
      usbPowerEn <= 1'b0;
    end else begin
      if (strb.shiftIn)       shiftQ <= {shiftQ[BYTE_W-2:0], strb.shiftBit};
      else if (strb.loadRead) shiftQ <= readByte;
      else if (strb.shiftOut) shiftQ <= {shiftQ[BYTE_W-2:0], 1'b0};
      if (strb.setIndex)      curIndex <= shiftQ;
      else if (strb.incIndex) curIndex <= curIndex + 1'b1;
      if (strb.writeReg && curIndex == IDX_USB) usbPowerEn <= shiftQ[0];
    end
  end

  assign addrMatch = (shiftQ[BYTE_W-1:1] == TARGET_ADDR);
  assign rwBit     = shiftQ[0];
  assign txMsb     = shiftQ[BYTE_W-1];
endmodule

// File: rtl/i2cStatusTarget.sv
module i2cStatusTarget
  import i2cStatusPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h55,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  output logic         sdaDriveLow,
  input  logic [7:0]   fwRevision,
  input  logic [7:0]   boardRevision,
  input  logic [7:0]   groupEnable,
  input  logic [15:0]  powerGood,
  input  logic         seqFaultN,
  output logic         usbPowerEn
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLines, filtLines;
  logic sclF, sdaF, addrMatch, rwBit, txMsb;
  logic [BYTE_W-1:0] curIndex;
  dpStrobe_t strb;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cLineFilter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .lineIn(rawLines[g]), .lineOut(filtLines[g]));
  end

  assign sclF = filtLines[1];
  assign sdaF = filtLines[0];

  i2cBusControl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .addrMatch(addrMatch),
    .rwBit(rwBit), .txMsb(txMsb), .strb(strb), .sdaDriveLow(sdaDriveLow));

  i2cRegDatapath #(.TARGET_ADDR(TARGET_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fwRevision(fwRevision),
    .boardRevision(boardRevision), .groupEnable(groupEnable), .powerGood(powerGood),
    .seqFaultN(seqFaultN), .addrMatch(addrMatch), .rwBit(rwBit), .txMsb(txMsb),
    .curIndex(curIndex), .usbPowerEn(usbPowerEn));
endmodule

// File: rtl/i2cStatusChecker.sv
module i2cStatusChecker
  import i2cStatusPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sclF,
  input logic              sdaDriveLow,
  input logic              usbPowerEn,
  input logic              incIndex,
  input logic              setIndex,
  input logic              writeReg,
  input logic              loadRead,
  input logic [BYTE_W-1:0] curIndex
);
  // R10
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclF);

  // R2
  index_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(incIndex) |-> curIndex == $past(curIndex) + 8'd1);

  // R2
  index_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({setIndex, writeReg, loadRead}) <= 1);

  // R6
  usb_only_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(usbPowerEn) |-> $past(writeReg) && $past(curIndex) == IDX_USB);

  // R7
  other_write_no_usb_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeReg && curIndex != IDX_USB |=> $stable(usbPowerEn));
endmodule

bind i2cStatusTarget i2cStatusChecker u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclF), .sdaDriveLow(sdaDriveLow),
  .usbPowerEn(usbPowerEn), .incIndex(strb.incIndex), .setIndex(strb.setIndex),
  .writeReg(strb.writeReg), .loadRead(strb.loadRead), .curIndex(curIndex));

// File: tb/i2cStatusTarget_bench.sv
module i2cStatusTarget_bench;
  localparam int Q = 12;
  localparam logic [6:0] ADDR = 7'h55;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaDriveLow, usbPowerEn, sdaLine;
  logic [7:0] fwRev = 8'h03, boardRev = 8'h02, grpEn = 8'h7F;
  logic [15:0] pg = 16'hFFFF;
  logic faultN = 1'b1;

  int checks = 0, errors = 0;
  logic modelUsb = 1'b0;
  bit quiet = 1, usbBusy = 0, done = 0;

  assign sdaLine = sdaDrv & ~sdaDriveLow;

  i2cStatusTarget u_i2cStatusTarget (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .fwRevision(fwRev), .boardRevision(boardRev), .groupEnable(grpEn),
    .powerGood(pg), .seqFaultN(faultN), .usbPowerEn(usbPowerEn));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expReg(input logic [7:0] idx);
    case (idx)
      8'h00: return fwRev;
      8'h01: return boardRev;
      8'h06: return grpEn;
      8'h08: return pg[7:0];
      8'h09: return pg[15:8];
      8'h0A: return {7'b0, faultN};
      8'h0E: return {7'b0, modelUsb};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqFor(input logic [7:0] idx);
    case (idx)
      8'h00, 8'h01: return "R3";
      8'h06, 8'h08, 8'h09: return "R4";
      8'h0A: return "R5";
      8'h0E: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Behavioural model compared on every clock.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (!usbBusy) chk(usbPowerEn === modelUsb, "R6 per-cycle enable", usbPowerEn, modelUsb);
      if (quiet) chk(sdaDriveLow === 1'b0, "R1 per-cycle released bus", sdaDriveLow, 0);
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1; sclDrv = 1; hold(Q);
    sdaDrv = 0; hold(Q);
    sclDrv = 0; hold(Q);
  endtask

  task automatic repStart();
    sdaDrv = 1; hold(Q);
    sclDrv = 1; hold(Q);
    sdaDrv = 0; hold(Q);
    sclDrv = 0; hold(Q);
  endtask

  task automatic stopCond();
    sdaDrv = 0; hold(Q);
    sclDrv = 1; hold(Q);
    sdaDrv = 1; hold(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; hold(Q);
    sclDrv = 1; hold(2 * Q);
    sclDrv = 0; hold(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaDrv = 1; hold(Q);
    sclDrv = 1; hold(Q);
    b = sdaLine; hold(Q);
    sclDrv = 0; hold(Q);
  endtask

  task automatic writeByte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    acked = !b;
  endtask

  task automatic readByte(output logic [7:0] d, input logic ackIt);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(!ackIt);
  endtask

  task automatic readBurst(input logic [7:0] first, input int n);
    logic a;
    logic [7:0] d, idx;
    quiet = 0;
    startCond();
    writeByte({ADDR, 1'b0}, a); chk(a, "R1 address ack", a, 1);
    writeByte(first, a);        chk(a, "R2 index ack", a, 1);
    repStart();
    writeByte({ADDR, 1'b1}, a); chk(a, "R1 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      idx = first + 8'(i);
      readByte(d, i < n - 1);
      chk(d === expReg(idx), {reqFor(idx), " R2 burst read"}, d, expReg(idx));
    end
    stopCond(); hold(Q);
    quiet = 1;
  endtask

  task automatic writeBurst(input logic [7:0] first, input logic [7:0] dq[$]);
    logic a;
    logic [7:0] idx;
    usbBusy = 1; quiet = 0;
    startCond();
    writeByte({ADDR, 1'b0}, a); chk(a, "R1 address ack", a, 1);
    writeByte(first, a);        chk(a, "R2 index ack", a, 1);
    for (int i = 0; i < dq.size(); i++) begin
      idx = first + 8'(i);
      writeByte(dq[i], a);
      chk(a, "R7 data byte ack", a, 1);
      if (idx == 8'h0E) modelUsb = dq[i][0];
    end
    stopCond(); hold(Q);
    quiet = 1; usbBusy = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a, b;
    logic [7:0] d;
    logic [7:0] dq[$];
    hold(10);
    rstN = 1;
    hold(5);

    // Reset state (R6, R1)
    chk(usbPowerEn === 1'b0, "R6 reset value", usbPowerEn, 0);
    chk(sdaDriveLow === 1'b0, "R1 idle after reset", sdaDriveLow, 0);

    // Default values across the whole map (R3 R4 R5 R6 R7)
    readBurst(8'h00, 16);

    // Enable write and read-back with upper bits masked (R6)
    dq = {8'hFF};
    writeBurst(8'h0E, dq);
    chk(usbPowerEn === 1'b1, "R6 enable set", usbPowerEn, 1);
    readBurst(8'h0E, 1);

    // START inside a data byte (R8)
    quiet = 0;
    startCond();
    writeByte({ADDR, 1'b0}, a); chk(a, "R8 address ack", a, 1);
    writeByte(8'h0E, a);        chk(a, "R8 index ack", a, 1);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    repStart();
    writeByte({ADDR, 1'b1}, a); chk(a, "R8 address after abort", a, 1);
    readByte(d, 1'b0);
    chk(d === 8'h01, "R8 index kept and partial byte dropped", d, 1);
    stopCond(); hold(Q); quiet = 1;
    chk(usbPowerEn === 1'b1, "R8 enable unchanged", usbPowerEn, 1);

    // Burst write over read-only indices up to 0x0E (R2, R7)
    dq = {};
    for (int i = 0; i < 15; i++) dq.push_back(8'(i * 17));
    writeBurst(8'h00, dq);
    chk(usbPowerEn === 1'b0, "R2 burst write reached 0x0E", usbPowerEn, 0);
    readBurst(8'h00, 16);

    // New input pattern (R3 R4 R5)
    fwRev = 8'hA5; boardRev = 8'h3C; grpEn = 8'h15; pg = 16'h1234; faultN = 1'b0;
    hold(2);
    readBurst(8'h00, 2);
    readBurst(8'h06, 5);

    // Index-only write, then a plain read from the stored index (R2 R4 R10)
    quiet = 0;
    startCond();
    writeByte({ADDR, 1'b0}, a); writeByte(8'h08, a); chk(a, "R2 index only ack", a, 1);
    stopCond();
    startCond();
    writeByte({ADDR, 1'b1}, a);
    readByte(d, 1'b1); chk(d === 8'h34, "R4/R10 stored index read", d, 8'h34);
    readByte(d, 1'b0); chk(d === 8'h12, "R4/R10 next index read", d, 8'h12);
    stopCond(); hold(Q); quiet = 1;

    // Wrong address: no ack, bus released, nothing written (R1)
    startCond();
    writeByte({7'h54, 1'b0}, a); chk(!a, "R1 wrong address not acked", a, 0);
    writeByte(8'h0E, a);         chk(!a, "R1 later byte not acked", a, 0);
    writeByte(8'h01, a);         chk(!a, "R1 data not acked", a, 0);
    stopCond(); hold(Q);
    chk(usbPowerEn === 1'b0, "R1 wrong address wrote nothing", usbPowerEn, 0);
    startCond();
    writeByte({7'h2A, 1'b1}, a); chk(!a, "R1 wrong read address not acked", a, 0);
    readByte(d, 1'b0); chk(d === 8'hFF, "R1 SDA released on foreign read", d, 8'hFF);
    stopCond(); hold(Q);

    // Short glitches on SCL and SDA are filtered (R9)
    usbBusy = 1; quiet = 0;
    startCond();
    writeByte({ADDR, 1'b0}, a); writeByte(8'h0E, a); chk(a, "R9 index ack", a, 1);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = (i == 0); hold(Q);
      sclDrv = 1; hold(Q);
      if (i == 0) begin sdaDrv = 0; hold(1); sdaDrv = 1; hold(Q - 1); end
      else hold(Q);
      sclDrv = 0; hold(4);
      if (i == 4) begin sclDrv = 1; hold(1); sclDrv = 0; end
      hold(Q - 4);
    end
    recvBit(b); chk(!b, "R9 glitched byte acked", !b, 1);
    stopCond(); hold(Q);
    modelUsb = 1'b1; usbBusy = 0; quiet = 1;
    chk(usbPowerEn === 1'b1, "R9 byte intact through glitches", usbPowerEn, 1);

    // Index wraps from 0xFF to 0x00 (R2)
    readBurst(8'hFF, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule